// File: doc/BRIEF.md
# RMII Receive Carrier/Data-Valid Decoder

This block sits on the MAC side of a reduced-pin Ethernet receive path. It samples the combined carrier/data-valid line and the two-bit receive data bus on the continuous 50 MHz reference clock. From them it rebuilds three things: a carrier-sense flag, a data-valid flag and a byte stream with a one-cycle strobe per byte.

A frame begins with a run of all-zero di-bits. The decoder skips that run and locks its nibble and byte alignment to the first `01` di-bit, which comes from the preamble. The combined line is then read two ways. Its value on the first di-bit of each nibble is the carrier, and its value on the second di-bit tells whether data is still flowing. A toggling pattern near the end of a frame therefore means the carrier has gone while buffered data is still arriving. A speed select chooses 100 Mb/s sampling, one di-bit per clock, or 10 Mb/s sampling, one di-bit every ten clocks.

Top module: `rmii_rx_decoder`

## Requirements
- R1: A synchronous active-high reset drives `carrier_sense`, `data_valid`, `rx_byte_vld` and `rx_byte` to zero and forgets any alignment or partial byte. A frame that arrives after reset is decoded from its own start.
- R2: In 100 Mb/s mode (`speed_10`=0) every clock is one di-bit sample. Four di-bits form a byte with the earliest di-bit in bits [1:0] and the latest in bits [7:6]. Each byte is shown on `rx_byte` with `rx_byte_vld` high for exactly one clock.
- R3: After `crs_dv` rises, di-bits are ignored until the first sample with `rxd`=`01`. That sample becomes bits [1:0] of the first byte, and `data_valid` is high from the clock after it.
- R4: Once alignment is set, `carrier_sense` takes the value of `crs_dv` sampled on the first di-bit of each nibble (di-bits 0 and 2 of a byte). Before alignment it is high from the first sample with `crs_dv` high.
- R5: When `crs_dv` is low on a nibble's first di-bit and high on its second, `carrier_sense` is low, `data_valid` stays high, and both di-bits are kept as data.
- R6: When `crs_dv` is low on both di-bits of a nibble, `data_valid` and `carrier_sense` fall after the second one, and any partially assembled byte is dropped with no strobe.
- R7: In 10 Mb/s mode (`speed_10`=1) the decoder takes its first sample on the clock where `crs_dv` rises from idle and then one sample every tenth clock. Values on the inputs between samples have no effect.
- R8: While idle, `rxd` is ignored whenever `crs_dv` is low. A carrier that never shows a `01` di-bit holds `carrier_sense` high and `data_valid` low, and returns to idle on the first sample with `crs_dv` low.
- R9: `data_valid` never rises unless `carrier_sense` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz receive reference clock |
| rst | input | 1 | Synchronous reset, active high |
| speed_10 | input | 1 | 1 selects 10 Mb/s sampling, 0 selects 100 Mb/s |
| crs_dv | input | 1 | Combined carrier-sense / data-valid line |
| rxd | input | 2 | Receive di-bit |
| rx_byte | output | 8 | Assembled receive byte |
| rx_byte_vld | output | 1 | One-clock strobe marking a new `rx_byte` |
| carrier_sense | output | 1 | Recovered carrier-sense flag |
| data_valid | output | 1 | Recovered data-valid flag |

## Verification
The hardest situation to reach is the frame tail, where `crs_dv` toggles for several nibbles before it falls on both di-bits. Reaching it needs nibble-exact stimulus that stays in phase with the alignment the decoder picked up from the preamble. The bench builds every frame as a di-bit sequence derived from its own byte list. It places the toggling nibbles on the last bytes and sometimes adds a half byte before the end, so that the discard path is reached as well. At 10 Mb/s it fills the nine clocks between samples with random `rxd` values, so that any sampling off the ten-clock grid shows up as corrupted bytes.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;

  localparam logic [1:0] ALIGN_DIBIT = 2'b01;
endpackage

// File: rtl/rmii_rx_tick.sv
module rmii_rx_tick #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic speed_10,
  input  logic idle,
  input  logic crs_dv,
  output logic tick
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [CW-1:0] cnt;

  always_comb begin
    if (!speed_10)  tick = 1'b1;
    else if (idle)  tick = crs_dv;
    else            tick = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (idle)                   cnt <= crs_dv ? CW'(1) : '0;
    else if (cnt == CW'(SLOW_DIV-1)) cnt <= '0;
    else                             cnt <= cnt + CW'(1);
  end

  // R7: in slow mode two samples are never on adjacent clocks once a frame runs
  a_r7_slow_spacing: assert property (@(posedge clk) disable iff (rst)
    (speed_10 && $past(speed_10) && !idle && $past(!idle) && tick) |-> !$past(tick));
endmodule

// File: rtl/rmii_rx_fsm.sv
module rmii_rx_fsm
  import rmii_rx_pkg::*;
#(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          crs_dv,
  input  logic [1:0]    rxd,
  output logic          idle,
  output logic [PW-1:0] pos,
  output logic          ev_start,
  output logic          ev_first,
  output logic          ev_pair,
  output logic          carrier_sense,
  output logic          data_valid
);
  rx_state_e state;
  logic      first_crs;
  logic      ev_open;
  logic      ev_drop;
  logic      ev_end;

  always_comb begin
    idle     = (state == ST_IDLE);
    ev_start = tick && crs_dv && (rxd == ALIGN_DIBIT) && (state != ST_DATA);
    ev_open  = tick && crs_dv && idle;
    ev_drop  = tick && !crs_dv && (state == ST_HUNT);
    ev_first = tick && (state == ST_DATA) && !pos[0];
    ev_pair  = tick && (state == ST_DATA) && pos[0] && (crs_dv || first_crs);
    ev_end   = tick && (state == ST_DATA) && pos[0] && !crs_dv && !first_crs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pos           <= '0;
      first_crs     <= 1'b0;
      carrier_sense <= 1'b0;
      data_valid    <= 1'b0;
    end else if (ev_start) begin
      state         <= ST_DATA;
      pos           <= PW'(1);
      first_crs     <= 1'b1;
      carrier_sense <= 1'b1;
      data_valid    <= 1'b1;
    end else if (ev_open) begin
      state         <= ST_HUNT;
      carrier_sense <= 1'b1;
    end else if (ev_drop) begin
      state         <= ST_IDLE;
      carrier_sense <= 1'b0;
    end else if (ev_first) begin
      first_crs     <= crs_dv;
      carrier_sense <= crs_dv;
      pos           <= pos + PW'(1);
    end else if (ev_pair) begin
      pos           <= pos + PW'(1);
    end else if (ev_end) begin
      state         <= ST_IDLE;
      pos           <= '0;
      carrier_sense <= 1'b0;
      data_valid    <= 1'b0;
    end
  end

  // R9: data-valid only opens while carrier is up
  a_r9_dv_needs_cs: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> carrier_sense);

  // R6: when data-valid ends, carrier is already down
  a_r6_end_without_cs: assert property (@(posedge clk) disable iff (rst)
    $fell(data_valid) |-> !carrier_sense);

  // R4: carrier can only come back on a first di-bit sample
  a_r4_cs_on_first: assert property (@(posedge clk) disable iff (rst)
    ($rose(carrier_sense) && $past(state == ST_DATA)) |-> $past(ev_first));
endmodule

// File: rtl/rmii_rx_pack.sv
module rmii_rx_pack #(
  parameter int BYTE_W = 8,
  parameter int PW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rxd,
  input  logic [PW-1:0]     pos,
  input  logic              ev_start,
  input  logic              ev_first,
  input  logic              ev_pair,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_byte_vld
);
  localparam int NDIB = BYTE_W / 2;

  logic [BYTE_W-1:0] shadow;
  logic              last_dibit;

  function automatic logic [BYTE_W-1:0] put_dibit(input logic [BYTE_W-1:0] b,
                                                  input logic [PW-1:0] p,
                                                  input logic [1:0] d);
    logic [BYTE_W-1:0] r;
    r = b;
    r[2*p +: 2] = d;
    return r;
  endfunction

  assign last_dibit = (pos == PW'(NDIB-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow      <= '0;
      rx_byte     <= '0;
      rx_byte_vld <= 1'b0;
    end else begin
      rx_byte_vld <= 1'b0;
      if (ev_start) begin
        shadow <= put_dibit('0, '0, rxd);
      end else if (ev_first || (ev_pair && !last_dibit)) begin
        shadow <= put_dibit(shadow, pos, rxd);
      end else if (ev_pair) begin
        rx_byte     <= put_dibit(shadow, pos, rxd);
        rx_byte_vld <= 1'b1;
      end
    end
  end

  // R2: a byte strobe is always a single clock wide
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    rx_byte_vld |=> !rx_byte_vld);
endmodule

// File: rtl/rmii_rx_decoder.sv
module rmii_rx_decoder #(
  parameter int BYTE_W   = 8,
  parameter int SLOW_DIV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              speed_10,
  input  logic              crs_dv,
  input  logic [1:0]        rxd,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_byte_vld,
  output logic              carrier_sense,
  output logic              data_valid
);
  localparam int NDIB = BYTE_W / 2;
  localparam int PW   = (NDIB > 1) ? $clog2(NDIB) : 1;

  logic          tick;
  logic          idle;
  logic [PW-1:0] pos;
  logic          ev_start;
  logic          ev_first;
  logic          ev_pair;

  rmii_rx_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst(rst), .speed_10(speed_10), .idle(idle),
    .crs_dv(crs_dv), .tick(tick)
  );

  rmii_rx_fsm #(.PW(PW)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .crs_dv(crs_dv), .rxd(rxd),
    .idle(idle), .pos(pos), .ev_start(ev_start), .ev_first(ev_first),
    .ev_pair(ev_pair), .carrier_sense(carrier_sense), .data_valid(data_valid)
  );

  rmii_rx_pack #(.BYTE_W(BYTE_W), .PW(PW)) u_pack (
    .clk(clk), .rst(rst), .rxd(rxd), .pos(pos), .ev_start(ev_start),
    .ev_first(ev_first), .ev_pair(ev_pair), .rx_byte(rx_byte),
    .rx_byte_vld(rx_byte_vld)
  );

  // R1: reset leaves every flag low on the following clock
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!carrier_sense && !data_valid && !rx_byte_vld));

  // R2: bytes only appear inside a valid-data window
  a_r2_strobe_in_frame: assert property (@(posedge clk) disable iff (rst)
    rx_byte_vld |-> data_valid);

  // R8: carrier cannot appear from idle without the line being high
  a_r8_idle_needs_line: assert property (@(posedge clk) disable iff (rst)
    ($rose(carrier_sense) && !$past(data_valid)) |-> $past(crs_dv));
endmodule

// File: tb/rmii_rx_decoder_bench.sv
module rmii_rx_decoder_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, speed_10, crs_dv;
  logic [1:0] rxd;
  logic [7:0] rx_byte;
  logic       rx_byte_vld, carrier_sense, data_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [7:0] got_q[$];

  rmii_rx_decoder u_rmii_rx_decoder (
    .clk(clk), .rst(rst), .speed_10(speed_10), .crs_dv(crs_dv), .rxd(rxd),
    .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld),
    .carrier_sense(carrier_sense), .data_valid(data_valid)
  );

  always @(negedge clk) if (!rst && rx_byte_vld) got_q.push_back(rx_byte);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] dib(input logic [7:0] b, input int i);
    return 2'((b >> (2 * i)) & 8'h03);
  endfunction

  task automatic dibit(input logic c, input logic [1:0] d, input int reps);
    for (int r = 0; r < reps; r++) begin
      @(negedge clk);
      crs_dv = c;
      rxd    = (r == 0) ? d : 2'($urandom);
      @(posedge clk);
    end
    #1;
  endtask

  task automatic idle_for(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      crs_dv = 1'b0;
      rxd    = 2'($urandom);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input bit slow, input int nz, input int nb,
                            input int ntog, input bit trunc);
    logic [7:0] q[$];
    int reps;
    bit tog_seen;
    string tag;
    reps     = slow ? 10 : 1;
    tag      = slow ? "R7" : "R2";
    tog_seen = 1'b0;
    q.push_back(8'h55);
    for (int k = 1; k < nb; k++) q.push_back(8'($urandom));
    got_q.delete();
    @(negedge clk);
    speed_10 = slow;
    for (int i = 0; i < nz; i++) begin
      dibit(1'b1, 2'b00, reps);
      if (i == 0) begin
        check("R4 cs after first carrier sample", carrier_sense, 1);
        check("R9 dv low before alignment", data_valid, 0);
      end
    end
    for (int k = 0; k < nb; k++) begin
      for (int i = 0; i < 4; i++) begin
        logic c;
        c = !((k >= nb - ntog) && (i % 2 == 0));
        dibit(c, dib(q[k], i), reps);
        if (k == 0 && i == 0) check("R3 dv after align di-bit", data_valid, 1);
        if (!c && !tog_seen) begin
          tog_seen = 1'b1;
          check("R5 cs low in toggle", carrier_sense, 0);
          check("R5 dv high in toggle", data_valid, 1);
        end
      end
    end
    if (trunc) begin
      dibit(1'b1, 2'($urandom), reps);
      dibit(1'b1, 2'($urandom), reps);
    end
    dibit(1'b0, 2'($urandom), reps);
    check("R6 dv held after one low di-bit", data_valid, 1);
    dibit(1'b0, 2'($urandom), reps);
    check("R6 dv low at end", data_valid, 0);
    check("R6 cs low at end", carrier_sense, 0);
    idle_for(3);
    check(trunc ? "R6 byte count with partial" : {tag, " byte count"}, got_q.size(), nb);
    for (int k = 0; k < nb && k < got_q.size(); k++)
      check({tag, " byte value"}, got_q[k], q[k]);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; speed_10 = 1'b0; crs_dv = 1'b1; rxd = 2'b01;
    repeat (3) @(posedge clk);
    #1;
    check("R1 cs after reset", carrier_sense, 0);
    check("R1 dv after reset", data_valid, 0);
    check("R1 strobe after reset", rx_byte_vld, 0);
    check("R1 byte after reset", rx_byte, 0);
    @(negedge clk);
    rst = 1'b0; crs_dv = 1'b0; rxd = 2'b00;

    // R8: idle, line low, preamble-like data ignored
    got_q.delete();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); crs_dv = 1'b0; rxd = 2'b01;
    end
    @(posedge clk); #1;
    check("R8 cs stays low while idle", carrier_sense, 0);
    check("R8 dv stays low while idle", data_valid, 0);
    check("R8 no bytes while idle", got_q.size(), 0);

    // R8: false carrier without alignment di-bit
    for (int i = 0; i < 12; i++) dibit(1'b1, 2'b10, 1);
    check("R8 cs during false carrier", carrier_sense, 1);
    check("R8 dv during false carrier", data_valid, 0);
    dibit(1'b0, 2'b01, 1);
    check("R8 cs drops after false carrier", carrier_sense, 0);
    check("R8 no bytes from false carrier", got_q.size(), 0);
    idle_for(2);

    send_frame(1'b0, 3, 4, 0, 1'b0);
    send_frame(1'b0, 0, 5, 2, 1'b0);
    send_frame(1'b0, 2, 3, 1, 1'b1);
    send_frame(1'b1, 2, 3, 0, 1'b0);
    send_frame(1'b1, 1, 4, 2, 1'b1);
    idle_for(4);

    // R1: reset mid-frame drops alignment and partial data
    @(negedge clk); speed_10 = 1'b0;
    got_q.delete();
    dibit(1'b1, 2'b01, 1);
    dibit(1'b1, 2'b11, 1);
    dibit(1'b1, 2'b10, 1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 dv cleared mid-frame", data_valid, 0);
    check("R1 cs cleared mid-frame", carrier_sense, 0);
    @(negedge clk); rst = 1'b0; crs_dv = 1'b0;
    idle_for(2);
    check("R1 no byte from aborted frame", got_q.size(), 0);
    send_frame(1'b0, 1, 2, 0, 1'b0);

    for (int f = 0; f < 20; f++) begin
      int nb;
      nb = 1 + int'($urandom % 6);
      send_frame(bit'($urandom % 2), int'($urandom % 5), nb,
                 int'($urandom % nb) % 3, bit'($urandom % 2));
      idle_for(1 + int'($urandom % 4));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule